// File: doc/BRIEF.md
# Transmit Descriptor Frame Walker

The walker follows a ring of transmit buffer descriptors and turns each one into a single data request toward the transmit path. A descriptor carries an ownership flag, a buffer address, a buffer length, a last-buffer flag and a ring-wrap flag. The descriptors sit at a fixed stride from a base address. A frame may span several buffers. A frame ends at the descriptor whose last-buffer flag is set, and the next descriptor opens a new frame.

Software starts the walker by writing a one-bit start control. The walker then keeps fetching descriptors until it finds one that is still owned by software (the ownership flag is set). If that descriptor opens a frame, the walker only stops and reports that it saw an owned descriptor. If the owned descriptor is found after a frame has already begun, the walker aborts that frame. It raises a transmit error and tells the downstream stage to send a corrupted FCS. The pointer to the first descriptor of each frame is kept, so a later start write replays the interrupted frame from its first buffer.

Top module: `tx_desc_walker`

## Requirements
- R1: After reset the walker is idle: walker_busy, desc_req_valid, buf_req_valid, tx_err, fcs_corrupt, used_seen and frame_end are all low. The first start write fetches the descriptor at BASE_ADDR.
- R2: desc_req_addr is the current descriptor pointer and is held stable while desc_req_valid waits for desc_req_ready. After each buffer is accepted, the pointer advances by DESC_STRIDE. If the descriptor's wrap flag is 1, the pointer returns to BASE_ADDR instead.
- R3: A descriptor with its ownership flag at 0 produces one data request carrying its buffer address and length. buf_req_valid, buf_req_addr and buf_req_len are held until buf_req_ready.
- R4: When a buffer whose last-buffer flag is 1 is accepted, frame_end pulses for one cycle in the next clock. The next descriptor fetched then opens a new frame, and its pointer becomes the frame's first pointer.
- R5: An ownership flag of 1 on the first descriptor of a frame stops the walker. used_seen pulses one cycle after the response, tx_err stays low, and a later start write re-reads that same descriptor.
- R6: An ownership flag of 1 on a later descriptor of a frame stops the walker. One cycle after the response, fcs_corrupt pulses for one cycle and tx_err goes high. tx_err stays high until the next accepted start write.
- R7: A start write while idle reloads the current pointer from the first pointer of the interrupted frame. It clears tx_err, and desc_req_valid rises in the next cycle.
- R8: A start write while walker_busy is high has no effect on the descriptor or data request sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_start | input | 1 | One-cycle write of the transmit start control bit |
| desc_req_valid | output | 1 | Descriptor read request |
| desc_req_ready | input | 1 | Descriptor read request accepted |
| desc_req_addr | output | AW | Address of the descriptor to read |
| desc_rsp_valid | input | 1 | Descriptor response present (one cycle) |
| desc_rsp_used | input | 1 | Ownership flag, 1 = still owned by software |
| desc_rsp_last | input | 1 | Last buffer of the frame |
| desc_rsp_wrap | input | 1 | Next descriptor is at BASE_ADDR |
| desc_rsp_buf_addr | input | AW | Buffer start address |
| desc_rsp_buf_len | input | LW | Buffer length in bytes |
| buf_req_valid | output | 1 | Buffer data request |
| buf_req_ready | input | 1 | Buffer data request accepted |
| buf_req_addr | output | AW | Buffer start address |
| buf_req_len | output | LW | Buffer length |
| walker_busy | output | 1 | Walker is active |
| tx_err | output | 1 | Frame aborted on a mid-frame owned descriptor |
| fcs_corrupt | output | 1 | One-cycle pulse: downstream must corrupt the FCS |
| used_seen | output | 1 | One-cycle pulse: owned descriptor at the start of a frame |
| frame_end | output | 1 | One-cycle pulse: last buffer of a frame accepted |

## Verification
A wrong first-pointer value stays hidden until a restart follows an abort. At that point the very first desc_req_addr after the start write shows it, one cycle after the write. A stale frame-open flag shows up at the next owned descriptor: the fault appears one cycle after that response, as the wrong choice between used_seen and fcs_corrupt. A bad advance or wrap shows up on the next descriptor request address. The bench compares every output with a behavioural model on every cycle, so each of these faults is reported in the cycle where it first reaches a port.

// File: rtl/txw_pkg.sv
package txw_pkg;

    typedef enum logic [1:0] {
        WK_IDLE  = 2'd0,
        WK_FETCH = 2'd1,
        WK_WAIT  = 2'd2,
        WK_XFER  = 2'd3
    } walk_state_e;

    typedef struct packed {
        logic used;
        logic last;
        logic wrap;
    } desc_flags_t;

    typedef struct packed {
        logic fcs_bad;
        logic used_hit;
        logic frm_end;
    } walk_pulse_t;

    localparam walk_pulse_t NO_PULSE = '{fcs_bad: 1'b0, used_hit: 1'b0, frm_end: 1'b0};

endpackage

// File: rtl/txw_ptr.sv
module txw_ptr #(
    parameter int          AW          = 32,
    parameter logic [31:0] BASE_ADDR   = 32'h0000_0100,
    parameter int          DESC_STRIDE = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rewind,
    input  logic          adv,
    input  logic          adv_wrap,
    input  logic          ld_first,
    output logic [AW-1:0] cur_ptr,
    output logic [AW-1:0] first_ptr
);
    localparam logic [AW-1:0] BASE_P   = BASE_ADDR[AW-1:0];
    localparam logic [AW-1:0] STRIDE_P = AW'(DESC_STRIDE);

    logic [AW-1:0] cur_q, first_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= BASE_P;
            first_q <= BASE_P;
        end else begin
            if (rewind)
                cur_q <= first_q;
            else if (adv)
                cur_q <= adv_wrap ? BASE_P : cur_q + STRIDE_P;
            if (ld_first)
                first_q <= cur_q;
        end
    end

    assign cur_ptr   = cur_q;
    assign first_ptr = first_q;
endmodule

// File: rtl/txw_ctrl.sv
module txw_ctrl
    import txw_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          dq_valid,
    input  logic          dq_ready,
    input  logic          rsp_valid,
    input  desc_flags_t   rsp_flags,
    input  logic [AW-1:0] rsp_addr,
    input  logic [LW-1:0] rsp_len,
    output logic          bq_valid,
    input  logic          bq_ready,
    output logic [AW-1:0] bq_addr,
    output logic [LW-1:0] bq_len,
    output logic          ld_first,
    output logic          adv,
    output logic          adv_wrap,
    output logic          rewind,
    output logic          busy,
    output logic          err,
    output walk_pulse_t   pulses
);
    walk_state_e   st_q;
    logic          in_frame_q;
    logic          err_q;
    desc_flags_t   flags_q;
    logic [AW-1:0] addr_q;
    logic [LW-1:0] len_q;
    walk_pulse_t   pulse_q;

    always_comb begin
        dq_valid = (st_q == WK_FETCH);
        bq_valid = (st_q == WK_XFER);
        rewind   = (st_q == WK_IDLE) && start;
        ld_first = dq_valid && dq_ready && !in_frame_q;
        adv      = bq_valid && bq_ready;
        adv_wrap = flags_q.wrap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= WK_IDLE;
            in_frame_q <= 1'b0;
            err_q      <= 1'b0;
            flags_q    <= '0;
            addr_q     <= '0;
            len_q      <= '0;
            pulse_q    <= NO_PULSE;
        end else begin
            pulse_q <= NO_PULSE;
            unique case (st_q)
                WK_IDLE: begin
                    if (start) begin
                        st_q  <= WK_FETCH;
                        err_q <= 1'b0;
                    end
                end
                WK_FETCH: begin
                    if (dq_ready)
                        st_q <= WK_WAIT;
                end
                WK_WAIT: begin
                    if (rsp_valid) begin
                        if (rsp_flags.used) begin
                            st_q <= WK_IDLE;
                            if (in_frame_q) begin
                                err_q           <= 1'b1;
                                pulse_q.fcs_bad <= 1'b1;
                                in_frame_q      <= 1'b0;
                            end else begin
                                pulse_q.used_hit <= 1'b1;
                            end
                        end else begin
                            st_q       <= WK_XFER;
                            in_frame_q <= 1'b1;
                            flags_q    <= rsp_flags;
                            addr_q     <= rsp_addr;
                            len_q      <= rsp_len;
                        end
                    end
                end
                WK_XFER: begin
                    if (bq_ready) begin
                        st_q <= WK_FETCH;
                        if (flags_q.last) begin
                            in_frame_q      <= 1'b0;
                            pulse_q.frm_end <= 1'b1;
                        end
                    end
                end
                default: st_q <= WK_IDLE;
            endcase
        end
    end

    assign bq_addr = addr_q;
    assign bq_len  = len_q;
    assign busy    = (st_q != WK_IDLE);
    assign err     = err_q;
    assign pulses  = pulse_q;
endmodule

// File: rtl/tx_desc_walker.sv
module tx_desc_walker
    import txw_pkg::*;
#(
    parameter int          AW          = 32,
    parameter int          LW          = 12,
    parameter logic [31:0] BASE_ADDR   = 32'h0000_0100,
    parameter int          DESC_STRIDE = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tx_start,
    output logic          desc_req_valid,
    input  logic          desc_req_ready,
    output logic [AW-1:0] desc_req_addr,
    input  logic          desc_rsp_valid,
    input  logic          desc_rsp_used,
    input  logic          desc_rsp_last,
    input  logic          desc_rsp_wrap,
    input  logic [AW-1:0] desc_rsp_buf_addr,
    input  logic [LW-1:0] desc_rsp_buf_len,
    output logic          buf_req_valid,
    input  logic          buf_req_ready,
    output logic [AW-1:0] buf_req_addr,
    output logic [LW-1:0] buf_req_len,
    output logic          walker_busy,
    output logic          tx_err,
    output logic          fcs_corrupt,
    output logic          used_seen,
    output logic          frame_end
);
    desc_flags_t   rsp_flags;
    walk_pulse_t   pulses;
    logic          ld_first, adv, adv_wrap, rewind;
    logic [AW-1:0] cur_ptr, first_ptr;

    assign rsp_flags = '{used: desc_rsp_used, last: desc_rsp_last, wrap: desc_rsp_wrap};

    txw_ptr #(
        .AW(AW), .BASE_ADDR(BASE_ADDR), .DESC_STRIDE(DESC_STRIDE)
    ) u_ptr (
        .clk(clk), .rst(rst), .rewind(rewind), .adv(adv), .adv_wrap(adv_wrap),
        .ld_first(ld_first), .cur_ptr(cur_ptr), .first_ptr(first_ptr)
    );

    txw_ctrl #(.AW(AW), .LW(LW)) u_ctrl (
        .clk(clk), .rst(rst), .start(tx_start),
        .dq_valid(desc_req_valid), .dq_ready(desc_req_ready),
        .rsp_valid(desc_rsp_valid), .rsp_flags(rsp_flags),
        .rsp_addr(desc_rsp_buf_addr), .rsp_len(desc_rsp_buf_len),
        .bq_valid(buf_req_valid), .bq_ready(buf_req_ready),
        .bq_addr(buf_req_addr), .bq_len(buf_req_len),
        .ld_first(ld_first), .adv(adv), .adv_wrap(adv_wrap), .rewind(rewind),
        .busy(walker_busy), .err(tx_err), .pulses(pulses)
    );

    assign desc_req_addr = cur_ptr;
    assign fcs_corrupt   = pulses.fcs_bad;
    assign used_seen     = pulses.used_hit;
    assign frame_end     = pulses.frm_end;
endmodule

// File: rtl/tx_walker_chk.sv
module tx_walker_chk #(
    parameter int AW = 32,
    parameter int LW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          tx_start,
    input logic          desc_req_valid,
    input logic          desc_req_ready,
    input logic [AW-1:0] desc_req_addr,
    input logic          buf_req_valid,
    input logic          buf_req_ready,
    input logic [AW-1:0] buf_req_addr,
    input logic [LW-1:0] buf_req_len,
    input logic          walker_busy,
    input logic          tx_err,
    input logic          fcs_corrupt,
    input logic          used_seen,
    input logic          frame_end
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !walker_busy |-> (!desc_req_valid && !buf_req_valid));

    // R2
    desc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (desc_req_valid && !desc_req_ready) |=> (desc_req_valid && $stable(desc_req_addr)));

    // R3
    buf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (buf_req_valid && !buf_req_ready) |=>
            (buf_req_valid && $stable(buf_req_addr) && $stable(buf_req_len)));

    // R4
    end_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        frame_end |-> ($past(buf_req_valid && buf_req_ready) && desc_req_valid));

    // R5
    used_clean_chk: assert property (@(posedge clk) disable iff (rst)
        used_seen |-> (!tx_err && !walker_busy));

    // R6
    abort_err_chk: assert property (@(posedge clk) disable iff (rst)
        fcs_corrupt |-> (tx_err && !walker_busy));

    // R6
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fcs_corrupt, used_seen, frame_end}));

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (!walker_busy && tx_start) |=> (desc_req_valid && !tx_err));
endmodule

bind tx_desc_walker tx_walker_chk #(.AW(AW), .LW(LW)) u_chk (.*);

// File: tb/tb_tx_desc_walker.sv
module tb_tx_desc_walker;
    localparam int          AW     = 32;
    localparam int          LW     = 12;
    localparam logic [31:0] BASE   = 32'h0000_0100;
    localparam int          STRIDE = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic          tx_start = 1'b0;
    logic          desc_req_valid, desc_req_ready = 1'b0;
    logic [AW-1:0] desc_req_addr;
    logic          desc_rsp_valid = 1'b0, desc_rsp_used = 1'b0, desc_rsp_last = 1'b0, desc_rsp_wrap = 1'b0;
    logic [AW-1:0] desc_rsp_buf_addr = '0;
    logic [LW-1:0] desc_rsp_buf_len = '0;
    logic          buf_req_valid, buf_req_ready = 1'b0;
    logic [AW-1:0] buf_req_addr;
    logic [LW-1:0] buf_req_len;
    logic          walker_busy, tx_err, fcs_corrupt, used_seen, frame_end;

    tx_desc_walker #(.AW(AW), .LW(LW), .BASE_ADDR(BASE), .DESC_STRIDE(STRIDE)) dut (.*);

    // descriptor ring held by the bench
    logic          m_used [8];
    logic          m_last [8];
    logic          m_wrap [8];
    logic [AW-1:0] m_badr [8];
    logic [LW-1:0] m_blen [8];

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: mode 0 idle, 1 asking, 2 awaiting, 3 sending
    int            r_mode;
    logic [31:0]   r_cur, r_first, r_baddr;
    logic [LW-1:0] r_blen;
    logic          r_open, r_err, r_fcs, r_used, r_end, r_last, r_wrap;

    always @(posedge clk) begin
        if (rst) begin
            r_mode = 0; r_cur = BASE; r_first = BASE; r_open = 0; r_err = 0;
            r_fcs = 0; r_used = 0; r_end = 0; r_last = 0; r_wrap = 0;
            r_baddr = 0; r_blen = 0;
        end else begin
            r_fcs = 0; r_used = 0; r_end = 0;
            if (r_mode == 0) begin
                if (tx_start) begin r_mode = 1; r_cur = r_first; r_err = 0; end
            end else if (r_mode == 1) begin
                if (desc_req_ready) begin
                    if (!r_open) r_first = r_cur;
                    r_mode = 2;
                end
            end else if (r_mode == 2) begin
                if (desc_rsp_valid) begin
                    if (desc_rsp_used) begin
                        r_mode = 0;
                        if (r_open) begin r_err = 1; r_fcs = 1; r_open = 0; end
                        else r_used = 1;
                    end else begin
                        r_mode = 3; r_open = 1;
                        r_baddr = desc_rsp_buf_addr; r_blen = desc_rsp_buf_len;
                        r_last = desc_rsp_last; r_wrap = desc_rsp_wrap;
                    end
                end
            end else begin
                if (buf_req_ready) begin
                    r_cur = r_wrap ? BASE : r_cur + STRIDE;
                    if (r_last) begin r_end = 1; r_open = 0; end
                    r_mode = 1;
                end
            end
        end
    end

    // compare, answer descriptor reads and toggle readies on the falling edge
    logic [15:0] lfsr = 16'hACE1;
    logic        pend = 1'b0;
    int          pdly = 0;
    logic [31:0] paddr = '0;

    always @(negedge clk) begin
        if (!rst) begin
            chk("R1 busy", walker_busy, r_mode != 0);
            chk("R2 desc_req_valid", desc_req_valid, r_mode == 1);
            if (r_mode == 1) chk("R2 R7 R8 desc_req_addr", desc_req_addr, r_cur);
            chk("R3 buf_req_valid", buf_req_valid, r_mode == 3);
            if (r_mode == 3) begin
                chk("R3 buf_req_addr", buf_req_addr, r_baddr);
                chk("R3 buf_req_len", buf_req_len, r_blen);
            end
            chk("R4 frame_end", frame_end, r_end);
            chk("R5 used_seen", used_seen, r_used);
            chk("R6 tx_err", tx_err, r_err);
            chk("R6 fcs_corrupt", fcs_corrupt, r_fcs);
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        desc_rsp_valid = 1'b0;
        if (pend) begin
            if (pdly == 0) begin
                int ix;
                ix = int'((paddr - BASE) / STRIDE) % 8;
                desc_rsp_valid    = 1'b1;
                desc_rsp_used     = m_used[ix];
                desc_rsp_last     = m_last[ix];
                desc_rsp_wrap     = m_wrap[ix];
                desc_rsp_buf_addr = m_badr[ix];
                desc_rsp_buf_len  = m_blen[ix];
                pend = 1'b0;
            end else pdly--;
        end
        desc_req_ready = lfsr[0] | lfsr[3];
        buf_req_ready  = lfsr[1] | lfsr[5];
        if (!rst && desc_req_valid && desc_req_ready) begin
            pend  = 1'b1;
            paddr = desc_req_addr;
            pdly  = int'(lfsr[7:6]) % 3;
        end
    end

    task automatic set_d(input int i, input logic u, input logic l, input logic w,
                         input logic [31:0] a, input int n);
        m_used[i] = u; m_last[i] = l; m_wrap[i] = w; m_badr[i] = a; m_blen[i] = LW'(n);
    endtask

    task automatic pulse_start();
        @(negedge clk); tx_start = 1'b1;
        @(negedge clk); tx_start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 2000 && walker_busy; k++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 8; i++) set_d(i, 1'b1, 1'b0, 1'b0, 32'h0, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 reset busy", walker_busy, 0);
        chk("R1 reset desc_req_valid", desc_req_valid, 0);
        chk("R1 reset buf_req_valid", buf_req_valid, 0);
        chk("R1 reset tx_err", tx_err, 0);

        // two frames then an owned descriptor opening a frame; extra start while busy (R8)
        set_d(0, 0, 0, 0, 32'h1000, 64);
        set_d(1, 0, 1, 0, 32'h2000, 100);
        set_d(2, 0, 1, 0, 32'h3000, 1);
        set_d(3, 1, 0, 0, 32'h4000, 20);
        @(negedge clk); tx_start = 1'b1;
        @(negedge clk); tx_start = 1'b0;
        chk("R1 first fetch at base", desc_req_addr, BASE);
        repeat (4) @(negedge clk);
        chk("R8 busy before extra start", walker_busy, 1);
        tx_start = 1'b1;
        @(negedge clk); tx_start = 1'b0;
        wait_idle();
        chk("R5 no error after owned first", tx_err, 0);

        // three-buffer frame cut by an owned descriptor in its middle
        set_d(3, 0, 0, 0, 32'h4000, 20);
        set_d(4, 0, 0, 0, 32'h4100, 30);
        set_d(5, 1, 0, 0, 32'h4200, 5);
        pulse_start();
        chk("R5 re-reads held descriptor", desc_req_addr, BASE + 3 * STRIDE);
        wait_idle();
        chk("R6 error held while idle", tx_err, 1);

        // restart replays from the frame's first descriptor, then wraps
        set_d(5, 0, 1, 0, 32'h4200, 5);
        set_d(6, 0, 1, 0, 32'h5000, 7);
        set_d(7, 0, 1, 1, 32'h6000, 9);
        set_d(0, 1, 0, 0, 32'h1000, 64);
        pulse_start();
        chk("R7 restart pointer", desc_req_addr, BASE + 3 * STRIDE);
        chk("R7 error cleared", tx_err, 0);
        wait_idle();

        // after the wrap the walker sits on descriptor 0 again
        pulse_start();
        chk("R2 wrap returned to base", desc_req_addr, BASE);
        wait_idle();
        chk("R5 stopped quietly", tx_err, 0);

        finish_run();
    end
endmodule